// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the command register of a SCSI bus controller. Every byte written there is split into a DMA request flag (bit 7) and a 7-bit operation code. The operation code is sorted into one of four groups. The group is then checked against the controller's link state, which is either idle (not connected) or connected as initiator, and against the bus phase that the sequencer reports. A command that passes this check is handed to the sequencer as a one-cycle strobe with its opcode and DMA flag. A command that fails, or a code that belongs to no group, raises the illegal-command bit of the interrupt register instead.

The block also owns the interrupt register and the interrupt-pending bit of the status byte. Sequencer events set interrupt bits. A read of the interrupt register shows the current value in that cycle and clears the register one cycle later.

The command input uses valid/ready. `cmd_ready` is held high, so a command is accepted in every cycle where `cmd_valid` is high and no back-pressure ever occurs. The sequencer strobe has no ready: it is a plain one-cycle pulse that the sequencer must capture. The event, link, phase, read and configuration pins are plain level or pulse inputs.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: `cmd_ready` is always 1. A command is accepted in every cycle where `cmd_valid` is 1. For an accepted legal command, `seq_stb` is 1 in the following cycle only, with `seq_op` equal to command bits 6:0 and `seq_dma` equal to command bit 7. Bit 7 plays no part in classification.
- R2: Opcodes 0x00, 0x01, 0x02 (chip reset) and 0x03 (bus reset) are legal in every link state and every phase.
- R3: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are legal only while `initiator` is 1.
- R4: Opcodes 0x20 through 0x2B are legal only while `initiator` is 1 and `bus_phase` (bits {msg, c/d, i/o}) is 3'b110 (message out) or 3'b111 (message in).
- R5: Opcodes 0x40 through 0x47 are legal only while `initiator` is 0.
- R6: A command is illegal if its opcode is legal in no state, or if it is listed but not allowed in the current link state or phase. An illegal command produces no strobe, and in the next cycle `irq_q` bit 6 (value 0x40) is 1.
- R7: An accepted bus reset (opcode 0x03) sets `irq_q` bit 7 (value 0x80) in the next cycle when `rst_report_off` is 0. It leaves bit 7 untouched when `rst_report_off` is 1.
- R8: Each 1 bit of `evt_set` is ORed into `irq_q` in the next cycle, with two exceptions. Bit 6 of `evt_set` is ignored. Bit 7 is ignored while `rst_report_off` is 1. Interrupt bits stay set until they are cleared.
- R9: `stat_byte` bit 7 is 1 exactly when `irq_q` is nonzero. Bits 2:0 follow `bus_phase`. Bits 6:3 are 0.
- R10: While `irq_rd` is 1, `irq_q` keeps its value. In the next cycle, `irq_q` and `stat_byte` bit 7 hold only the bits set in that same cycle.
- R11: An accepted chip reset (opcode 0x02) makes `initiator` 0 and clears `irq_q` in the next cycle. This overrides any events, reads or link pulses in the same cycle.
- R12: `link_up` makes `initiator` 1 in the next cycle and `link_down` makes it 0. If both are 1 in the same cycle, `link_down` wins.
- R13: During and right after reset, `irq_q` is 0, `stat_byte` bit 7 is 0, `seq_stb` is 0 and `initiator` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte is present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_data | input | 8 | Command byte: bit 7 is the DMA request, bits 6:0 are the opcode |
| bus_phase | input | 3 | Current bus phase {msg, c/d, i/o} |
| link_up | input | 1 | Pulse: now connected as initiator |
| link_down | input | 1 | Pulse: connection dropped |
| evt_set | input | 8 | Interrupt bits raised by the sequencer |
| rst_report_off | input | 1 | Suppress bus-reset interrupt reports |
| irq_rd | input | 1 | Interrupt register is being read |
| irq_q | output | 8 | Interrupt register |
| stat_byte | output | 8 | Status byte: interrupt pending (bit 7) and phase (bits 2:0) |
| initiator | output | 1 | Link state: 1 = connected as initiator |
| seq_stb | output | 1 | One-cycle strobe for a legal command |
| seq_op | output | 7 | Opcode of the strobed command |
| seq_dma | output | 1 | DMA request of the strobed command |

## Verification
The assertions assume that `rst_n` is synchronous, that `bus_phase` is stable between clock edges, and that reads and events are single-cycle pulses. The stimulus meets these assumptions by driving every input only on the falling clock edge. It also deliberately creates the colliding cases: link up and link down together, and a read or event in the same cycle as a chip reset. The random phase keeps covering message and non-message phases, so group 3 commands are seen both legal and illegal. Random commands are biased toward the listed groups, with occasional arbitrary bytes, so that every group meets both link states.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int OP_W   = CMD_W - 1;
  localparam int IRQ_W  = 8;
  localparam int PH_W   = 3;
  localparam int STAT_W = 8;

  localparam int IRQ_ILLEGAL_BIT = 6;
  localparam int IRQ_BUSRST_BIT  = 7;

  localparam logic [PH_W-1:0] PH_MSG_OUT = 3'b110;
  localparam logic [PH_W-1:0] PH_MSG_IN  = 3'b111;

  localparam logic [OP_W-1:0] OP_CHIP_RESET = 7'h02;
  localparam logic [OP_W-1:0] OP_BUS_RESET  = 7'h03;

  typedef enum logic [2:0] {
    GRP_NONE = 3'd0,
    GRP_MISC = 3'd1,
    GRP_CONN = 3'd2,
    GRP_MSG  = 3'd3,
    GRP_IDLE = 3'd4
  } cmd_grp_e;

  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_INIT = 1'b1
  } link_e;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import scsi_cmd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output cmd_grp_e        grp
);
  always_comb begin
    grp = GRP_NONE;
    if (op <= 7'h03)
      grp = GRP_MISC;
    else if (op == 7'h10 || op == 7'h11 || op == 7'h12 ||
             op == 7'h18 || op == 7'h1A || op == 7'h1B)
      grp = GRP_CONN;
    else if (op >= 7'h20 && op <= 7'h2B)
      grp = GRP_MSG;
    else if (op >= 7'h40 && op <= 7'h47)
      grp = GRP_IDLE;
  end
endmodule

// File: rtl/link_tracker.sv
module link_tracker
  import scsi_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  link_up,
  input  logic  link_down,
  input  logic  chip_rst,
  output link_e link_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      link_q <= LINK_IDLE;
    else if (chip_rst || link_down)
      link_q <= LINK_IDLE;
    else if (link_up)
      link_q <= LINK_INIT;
  end

  assert_chiprst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> link_q == LINK_IDLE);
  assert_up_connects_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !link_down && !chip_rst) |=> link_q == LINK_INIT);
  assert_down_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    link_down |=> link_q == LINK_IDLE);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import scsi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic             clr_all,
  input  logic             rd,
  output logic [IRQ_W-1:0] irq_q,
  output logic             pend_q
);
  logic [IRQ_W-1:0] irq_d;
  logic             pend_d;

  always_comb begin
    if (clr_all) begin
      irq_d  = '0;
      pend_d = 1'b0;
    end else begin
      irq_d  = (rd ? '0 : irq_q) | set_vec;
      pend_d = (rd ? 1'b0 : pend_q) | (|set_vec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      pend_q <= pend_d;
    end
  end

  assert_pend_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == (|irq_q));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr_all && set_vec == '0) |=> (irq_q == '0 && !pend_q));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !clr_all) |=> ((irq_q & $past(irq_q)) == $past(irq_q)));
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> irq_q == '0);
endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
  import scsi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [PH_W-1:0]   bus_phase,
  input  logic              link_up,
  input  logic              link_down,
  input  logic [IRQ_W-1:0]  evt_set,
  input  logic              rst_report_off,
  input  logic              irq_rd,
  output logic [IRQ_W-1:0]  irq_q,
  output logic [STAT_W-1:0] stat_byte,
  output logic              initiator,
  output logic              seq_stb,
  output logic [OP_W-1:0]   seq_op,
  output logic              seq_dma
);
  logic [OP_W-1:0]  op;
  logic             dma_req;
  cmd_grp_e         grp;
  link_e            link_q;
  logic             in_msg_phase;
  logic             legal;
  logic             accept;
  logic             go;
  logic             chip_rst_go;
  logic             bus_rst_go;
  logic [IRQ_W-1:0] set_vec;
  logic             pend_q;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid && cmd_ready;
  assign op        = cmd_data[OP_W-1:0];
  assign dma_req   = cmd_data[CMD_W-1];

  cmd_classify u_classify (
    .op  (op),
    .grp (grp)
  );

  assign in_msg_phase = (bus_phase == PH_MSG_OUT) || (bus_phase == PH_MSG_IN);

  always_comb begin
    unique case (grp)
      GRP_MISC: legal = 1'b1;
      GRP_CONN: legal = (link_q == LINK_INIT);
      GRP_MSG:  legal = (link_q == LINK_INIT) && in_msg_phase;
      GRP_IDLE: legal = (link_q == LINK_IDLE);
      default:  legal = 1'b0;
    endcase
  end

  assign go          = accept && legal;
  assign chip_rst_go = go && (op == OP_CHIP_RESET);
  assign bus_rst_go  = go && (op == OP_BUS_RESET);

  always_comb begin
    set_vec = evt_set;
    set_vec[IRQ_ILLEGAL_BIT] = accept && !legal;
    set_vec[IRQ_BUSRST_BIT]  = !rst_report_off && (evt_set[IRQ_BUSRST_BIT] || bus_rst_go);
  end

  link_tracker u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .link_down (link_down),
    .chip_rst  (chip_rst_go),
    .link_q    (link_q)
  );

  irq_bank u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_all (chip_rst_go),
    .rd      (irq_rd),
    .irq_q   (irq_q),
    .pend_q  (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_stb <= 1'b0;
      seq_op  <= '0;
      seq_dma <= 1'b0;
    end else begin
      seq_stb <= go;
      if (go) begin
        seq_op  <= op;
        seq_dma <= dma_req;
      end
    end
  end

  assign initiator = (link_q == LINK_INIT);
  assign stat_byte = {pend_q, {(STAT_W-1-PH_W){1'b0}}, bus_phase};

  assert_stb_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stb |-> $past(accept));
  assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal) |=> (!seq_stb && irq_q[IRQ_ILLEGAL_BIT]));
  assert_conn_grp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grp == GRP_CONN && link_q == LINK_IDLE) |=> !seq_stb);
  assert_idle_grp_conn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grp == GRP_IDLE && link_q == LINK_INIT) |=> !seq_stb);
  assert_msg_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grp == GRP_MSG && !in_msg_phase) |=> !seq_stb);
  assert_busrst_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_go && !rst_report_off) |=> irq_q[IRQ_BUSRST_BIT]);
endmodule

// File: tb/test_scsi_cmd_decoder.sv
module test_scsi_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = '0;
  logic [2:0] bus_phase = '0;
  logic       link_up = 1'b0, link_down = 1'b0;
  logic [7:0] evt_set = '0;
  logic       rst_report_off = 1'b0;
  logic       irq_rd = 1'b0;
  logic [7:0] irq_q, stat_byte;
  logic       initiator, seq_stb, seq_dma;
  logic [6:0] seq_op;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  bit         m_init = 0, m_pend = 0, m_stb = 0, m_dma = 0;
  logic [7:0] m_irq = '0;
  logic [6:0] m_op = '0;
  string      t_stb = "R13", t_irq = "R13", t_link = "R13";

  always #4 clk = ~clk;

  scsi_cmd_decoder i_scsi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .bus_phase(bus_phase), .link_up(link_up),
    .link_down(link_down), .evt_set(evt_set), .rst_report_off(rst_report_off),
    .irq_rd(irq_rd), .irq_q(irq_q), .stat_byte(stat_byte), .initiator(initiator),
    .seq_stb(seq_stb), .seq_op(seq_op), .seq_dma(seq_dma)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit ref_legal(input logic [6:0] op, input bit conn, input logic [2:0] ph);
    if (op <= 7'h03) return 1'b1;
    if (op inside {7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B}) return conn;
    if (op >= 7'h20 && op <= 7'h2B) return conn && (ph == 3'b110 || ph == 3'b111);
    if (op >= 7'h40 && op <= 7'h47) return !conn;
    return 1'b0;
  endfunction

  function automatic string grp_tag(input logic [6:0] op);
    if (op <= 7'h03) return "R2";
    if (op[6:4] == 3'h1) return "R3";
    if (op[6:4] == 3'h2) return "R4";
    if (op[6:4] == 3'h4) return "R5";
    return "R6";
  endfunction

  task automatic compare_all();
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(seq_stb == m_stb, t_stb, "seq_stb", seq_stb, m_stb);
    if (m_stb) begin
      check(seq_op == m_op, "R1", "seq_op", seq_op, m_op);
      check(seq_dma == m_dma, "R1", "seq_dma", seq_dma, m_dma);
    end
    check(irq_q == m_irq, t_irq, "irq_q", irq_q, m_irq);
    check(stat_byte == {m_pend, 4'b0000, bus_phase}, "R9", "stat_byte",
          stat_byte, {m_pend, 4'b0000, bus_phase});
    check(initiator == m_init, t_link, "initiator", initiator, m_init);
  endtask

  task automatic cycle(input bit v, input logic [7:0] c, input bit up, input bit dn,
                       input logic [2:0] ph, input logic [7:0] ev, input bit rd, input bit off);
    bit legal, chip;
    logic [7:0] setv;
    cmd_valid = v; cmd_data = c; link_up = up; link_down = dn;
    bus_phase = ph; evt_set = ev; irq_rd = rd; rst_report_off = off;
    legal = v && ref_legal(c[6:0], m_init, ph);
    chip  = legal && c[6:0] == 7'h02;
    setv  = ev;
    setv[6] = v && !legal;
    setv[7] = !off && (ev[7] || (legal && c[6:0] == 7'h03));
    t_stb = v ? (legal ? grp_tag(c[6:0]) : "R6") : "R1";
    if (chip) t_irq = "R11";
    else if (rd) t_irq = "R10";
    else if (v && !legal) t_irq = "R6";
    else if (legal && c[6:0] == 7'h03) t_irq = "R7";
    else t_irq = "R8";
    t_link = chip ? "R11" : "R12";
    if (chip) begin
      m_irq = '0; m_pend = 0; m_init = 0;
    end else begin
      m_irq  = (rd ? 8'h00 : m_irq) | setv;
      m_pend = (rd ? 1'b0 : m_pend) | (|setv);
      if (dn) m_init = 0;
      else if (up) m_init = 1;
    end
    m_stb = legal;
    if (legal) begin
      m_op = c[6:0]; m_dma = c[7];
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(input logic [7:0] c, input logic [2:0] ph);
    cycle(1, c, 0, 0, ph, 8'h00, 0, 0);
  endtask

  task automatic idle(input bit rd);
    cycle(0, 8'h00, 0, 0, 3'b000, 8'h00, rd, 0);
  endtask

  function automatic logic [7:0] pick_cmd();
    logic [7:0] c;
    int sel = $urandom_range(0, 5);
    case (sel)
      0: c = 8'($urandom_range(0, 3));
      1: begin
        logic [7:0] g2 [6] = '{8'h10, 8'h11, 8'h12, 8'h18, 8'h1A, 8'h1B};
        c = g2[$urandom_range(0, 5)];
      end
      2: c = 8'h20 + 8'($urandom_range(0, 12));
      3: c = 8'h40 + 8'($urandom_range(0, 8));
      default: c = 8'($urandom_range(0, 255));
    endcase
    c[7] = $urandom_range(0, 1) != 0;
    return c;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq_q == 8'h00, "R13", "irq_q in reset", irq_q, 0);
    check(stat_byte[7] == 1'b0, "R13", "pending in reset", stat_byte[7], 0);
    check(seq_stb == 1'b0, "R13", "seq_stb in reset", seq_stb, 0);
    check(initiator == 1'b0, "R13", "initiator in reset", initiator, 0);
    rst_n = 1'b1;
    idle(0);
    check(irq_q == 8'h00 && initiator == 1'b0, "R13", "state after reset",
          {initiator, irq_q}, 0);

    cmd(8'h41, 3'b000);
    cmd(8'hC4, 3'b000);
    cmd(8'h10, 3'b000);
    idle(1);
    idle(0);
    cmd(8'h20, 3'b110);
    cmd(8'h01, 3'b000);
    cmd(8'h00, 3'b101);
    idle(1);

    cycle(0, 8'h00, 1, 0, 3'b000, 8'h00, 0, 0);
    cmd(8'h10, 3'b000);
    cmd(8'h9A, 3'b001);
    cmd(8'h45, 3'b000);
    cmd(8'h28, 3'b000);
    cmd(8'h28, 3'b110);
    cmd(8'hAB, 3'b111);
    cmd(8'h2C, 3'b111);
    cmd(8'h13, 3'b000);
    cmd(8'h7F, 3'b000);
    idle(1);

    cycle(1, 8'h03, 0, 0, 3'b000, 8'h00, 0, 0);
    idle(1);
    cycle(1, 8'h03, 0, 0, 3'b000, 8'h00, 0, 1);
    cycle(0, 8'h00, 0, 0, 3'b000, 8'hC0, 0, 1);
    cycle(0, 8'h00, 0, 0, 3'b000, 8'hC1, 0, 0);
    cycle(0, 8'h00, 0, 0, 3'b000, 8'h18, 1, 0);
    idle(1);
    cycle(0, 8'h00, 0, 0, 3'b000, 8'h24, 0, 0);
    cycle(1, 8'h82, 1, 0, 3'b000, 8'h3F, 1, 0);
    cmd(8'h42, 3'b000);
    cycle(0, 8'h00, 1, 1, 3'b000, 8'h00, 0, 0);
    cmd(8'h47, 3'b000);

    for (int i = 0; i < 4000; i++) begin
      bit v = $urandom_range(0, 3) != 0;
      bit up = $urandom_range(0, 7) == 0;
      bit dn = $urandom_range(0, 15) == 0;
      logic [2:0] ph = 3'($urandom_range(0, 7));
      logic [7:0] ev = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
      bit rd = $urandom_range(0, 5) == 0;
      bit off = $urandom_range(0, 3) == 0;
      cycle(v, pick_cmd(), up, dn, ph, ev, rd, off);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule